// File: doc/BRIEF.md
# Packet Bit-Select Table Indexer

This block classifies a packet by looking at eight header bits whose locations software picks. Packet bytes arrive one per cycle with start and end markers and a port number. The low two bits of the port number choose one of four extractor setups.

Each setup holds a byte skip, eight bit positions with their own valid flags, an index offset, a tag byte and a 16-bit upper tag. The block gathers the eight selected bits into an 8-bit value and adds the offset to form a 9-bit index. It reads that index from a 512-entry result table.

The result is a QoS value, a group, a tag type and a 32-bit tag built from three sources: the table entry, the extractor setup and a per-packet include-port flag. A single write port loads the extractor setups and the table. The result comes out as a one-cycle pulse, two cycles after the last byte the index depends on.

Top module: `bitsel_indexer`

## Requirements
- R1: The extractor setup used for a packet is the one numbered by bits 1:0 of `pkt_port`, sampled on the start byte.
- R2: A write with `cfg_kind`=0 stores `cfg_wdata[6:0]` as position `cfg_addr[2:0]` of extractor `cfg_ext` and sets that position's valid flag. A position whose flag is clear contributes 0 to the index.
- R3: Index bit y is taken from packet byte skip + (position_y >> 3), counting the start byte as byte 0. Within that byte it is bit 7 − (position_y mod 8), so position 0 is the most significant bit.
- R4: A write with `cfg_kind`=1 sets skip = `cfg_wdata[6:0]` (0..64), offset = `cfg_wdata[16:8]` and tag byte = `cfg_wdata[31:24]`. The index is the collected 8-bit value plus the offset, modulo 512.
- R5: A write with `cfg_kind`=3 stores table entry `cfg_addr`: tag = `cfg_wdata[7:0]`, tag type = `cfg_wdata[9:8]`, group = `cfg_wdata[17:12]`, QoS = `cfg_wdata[22:20]`. The result fields are those of the entry at the computed index.
- R6: `res_tag` carries the table tag in bits 7:0 and the extractor tag byte in bits 15:8. Bits 31:16 hold the extractor's upper tag, which a write with `cfg_kind`=2 sets from `cfg_wdata[15:0]`, when `pkt_incl_port` was low on the start byte, and are zero when it was high.
- R7: `res_valid` pulses exactly once per packet, two clock edges after the edge that takes the last needed byte. The last needed byte is skip + the largest (position >> 3) over valid positions, or skip if no position is valid. Bytes after it are ignored.
- R8: If the end byte arrives before the last needed byte, the result fires on the end byte and bits at missing bytes read as 0.
- R9: After reset `res_valid` is low and every setup is zero with all valid flags clear, so the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 position, 1 skip/offset/tag byte, 2 upper tag, 3 table entry |
| cfg_ext | input | 2 | Extractor number for kinds 0 to 2 |
| cfg_addr | input | 9 | Position slot (bits 2:0) or table entry number |
| cfg_wdata | input | 32 | Write data |
| pkt_valid | input | 1 | A packet byte is present |
| pkt_sop | input | 1 | Byte is the first of its packet |
| pkt_eop | input | 1 | Byte is the last of its packet |
| pkt_data | input | 8 | Packet byte |
| pkt_port | input | 6 | Input port number, valid with the start byte |
| pkt_incl_port | input | 1 | Port's include-port flag, valid with the start byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_qos | output | 3 | QoS from the table entry |
| res_grp | output | 6 | Group from the table entry |
| res_tt | output | 2 | Tag type from the table entry |
| res_tag | output | 32 | Composed tag |

## Verification
The assertions take for granted three things about the inputs. Every packet's bytes arrive in order, beginning with a start byte. The configuration of an extractor does not change while one of its packets is in flight. The skip stays within 0 to 64.

The stimulus keeps within these limits in three ways. It performs all writes between packets. It draws skips only from that range. It sends each packet as an unbroken run of bytes followed by idle cycles.

Random packets of 1 to 90 bytes run against random setups. Directed cases cover the largest skip with the farthest position, truncated packets, offset wraparound, bit ordering inside a byte and never-written positions.

// File: rtl/bitsel_indexer.sv
module bitsel_indexer #(
  parameter int NUM_EXT = 4,
  parameter int NUM_POS = 8,
  parameter int POS_W   = 7,
  parameter int SKIP_W  = 7,
  parameter int IDX_W   = 9,
  parameter int QOS_W   = 3,
  parameter int GRP_W   = 6,
  parameter int TT_W    = 2,
  parameter int PORT_W  = 6,
  parameter int CNT_W   = 8,
  localparam int EXT_W  = $clog2(NUM_EXT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [EXT_W-1:0]  cfg_ext,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              pkt_valid,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  input  logic [7:0]        pkt_data,
  input  logic [PORT_W-1:0] pkt_port,
  input  logic              pkt_incl_port,
  output logic              res_valid,
  output logic [QOS_W-1:0]  res_qos,
  output logic [GRP_W-1:0]  res_grp,
  output logic [TT_W-1:0]   res_tt,
  output logic [31:0]       res_tag
);
  localparam int SLOT_W = $clog2(NUM_POS);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int ENT_W  = QOS_W + GRP_W + TT_W + 8;

  logic [POS_W-1:0]   pos_q   [NUM_EXT][NUM_POS];
  logic [NUM_POS-1:0] vld_q   [NUM_EXT];
  logic [SKIP_W-1:0]  skip_q  [NUM_EXT];
  logic [IDX_W-1:0]   off_q   [NUM_EXT];
  logic [7:0]         tagb_q  [NUM_EXT];
  logic [15:0]        upper_q [NUM_EXT];
  logic [ENT_W-1:0]   tbl_q   [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_EXT; e++) begin
        vld_q[e]   <= '0;
        skip_q[e]  <= '0;
        off_q[e]   <= '0;
        tagb_q[e]  <= '0;
        upper_q[e] <= '0;
        for (int s = 0; s < NUM_POS; s++) pos_q[e][s] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_kind)
        2'd0: begin
          pos_q[cfg_ext][cfg_addr[SLOT_W-1:0]] <= cfg_wdata[POS_W-1:0];
          vld_q[cfg_ext][cfg_addr[SLOT_W-1:0]] <= 1'b1;
        end
        2'd1: begin
          skip_q[cfg_ext] <= cfg_wdata[SKIP_W-1:0];
          off_q[cfg_ext]  <= cfg_wdata[8 +: IDX_W];
          tagb_q[cfg_ext] <= cfg_wdata[31:24];
        end
        2'd2: upper_q[cfg_ext] <= cfg_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (cfg_we && cfg_kind == 2'd3)
      tbl_q[cfg_addr] <= {cfg_wdata[20 +: QOS_W], cfg_wdata[12 +: GRP_W],
                          cfg_wdata[8 +: TT_W], cfg_wdata[7:0]};

  logic               busy_q, incl_q, s1_v;
  logic [EXT_W-1:0]   ext_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_POS-1:0] acc_q;
  logic [IDX_W-1:0]   s1_idx;
  logic [23:0]        s1_tag;

  wire               active_now = pkt_valid && (pkt_sop || busy_q);
  wire [EXT_W-1:0]   ext_now    = pkt_sop ? pkt_port[EXT_W-1:0] : ext_q;
  wire [CNT_W-1:0]   cnt_now    = pkt_sop ? '0 : cnt_q;
  wire               incl_now   = pkt_sop ? pkt_incl_port : incl_q;

  logic [NUM_POS-1:0] hit, smp, acc_now;
  logic [CNT_W-1:0]   far_now, need_now;

  always_comb begin
    far_now = '0;
    for (int y = 0; y < NUM_POS; y++) begin
      logic [CNT_W-1:0] rel;
      rel    = CNT_W'(pos_q[ext_now][y][POS_W-1:3]);
      hit[y] = vld_q[ext_now][y] && (cnt_now == CNT_W'(skip_q[ext_now]) + rel);
      smp[y] = pkt_data[~pos_q[ext_now][y][2:0]];
      if (vld_q[ext_now][y] && rel > far_now) far_now = rel;
    end
    need_now = CNT_W'(skip_q[ext_now]) + far_now;
    acc_now  = (pkt_sop ? '0 : acc_q) | (hit & smp);
  end

  wire fire = active_now && (pkt_eop || cnt_now == need_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      s1_v   <= 1'b0;
    end else begin
      s1_v <= fire;
      if (fire)                      busy_q <= 1'b0;
      else if (pkt_valid && pkt_sop) busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (active_now) begin
      cnt_q  <= cnt_now + 1'b1;
      acc_q  <= acc_now;
      ext_q  <= ext_now;
      incl_q <= incl_now;
    end
    if (fire) begin
      s1_idx <= IDX_W'({1'b0, acc_now}) + off_q[ext_now];
      s1_tag <= {incl_now ? 16'h0 : upper_q[ext_now], tagb_q[ext_now]};
    end
  end

  logic [ENT_W-1:0] ent;
  always_ff @(posedge clk) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= s1_v;
    if (s1_v) ent <= tbl_q[s1_idx];
  end
  logic [23:0] tag_hi;
  always_ff @(posedge clk) if (s1_v) tag_hi <= s1_tag;

  assign {res_qos, res_grp, res_tt} = ent[ENT_W-1:8];
  assign res_tag = {tag_hi, ent[7:0]};

  logic unused_bits;
  assign unused_bits = ^{pkt_port, cfg_wdata[23]};

  assert_pos_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd0) |=> vld_q[$past(cfg_ext)][$past(cfg_addr[SLOT_W-1:0])]);
  assert_no_byte_no_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !s1_v);
  assert_index_to_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> res_valid);
  assert_single_byte_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_sop && pkt_eop && pkt_incl_port) |=> ##1 (res_valid && res_tag[31:16] == 16'h0));
endmodule

// File: tb/bitsel_indexer_test.sv
module bitsel_indexer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_kind = 0, cfg_ext = 0;
  logic [8:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic pkt_valid = 0, pkt_sop = 0, pkt_eop = 0, pkt_incl_port = 0;
  logic [7:0] pkt_data = 0; logic [5:0] pkt_port = 0;
  logic res_valid; logic [2:0] res_qos; logic [5:0] res_grp; logic [1:0] res_tt; logic [31:0] res_tag;

  bitsel_indexer uut (.clk, .rst_n, .cfg_we, .cfg_kind, .cfg_ext, .cfg_addr, .cfg_wdata,
    .pkt_valid, .pkt_sop, .pkt_eop, .pkt_data, .pkt_port, .pkt_incl_port,
    .res_valid, .res_qos, .res_grp, .res_tt, .res_tag);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int pulses, got_cyc; logic [2:0] g_qos; logic [5:0] g_grp; logic [1:0] g_tt; logic [31:0] g_tag;
  always @(negedge clk) if (res_valid) begin
    pulses++; got_cyc = cyc; g_qos = res_qos; g_grp = res_grp; g_tt = res_tt; g_tag = res_tag;
  end

  int m_pos [4][8]; bit m_vld [4][8]; int m_skip [4], m_off [4], m_tagb [4], m_up [4];
  int t_qos [512], t_grp [512], t_tt [512], t_tag [512];
  logic [7:0] pkt [128];

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cfg_write(int kind, int e, int addr, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_ext = 2'(e); cfg_addr = 9'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_pos(int e, int s, int p);
    cfg_write(0, e, s, 32'(p)); m_pos[e][s] = p; m_vld[e][s] = 1;
  endtask
  task automatic set_ext(int e, int skip, int off, int tagb);
    cfg_write(1, e, 0, (32'(tagb) << 24) | (32'(off) << 8) | 32'(skip));
    m_skip[e] = skip; m_off[e] = off; m_tagb[e] = tagb;
  endtask
  task automatic set_up(int e, int u);
    cfg_write(2, e, 0, 32'(u)); m_up[e] = u;
  endtask
  task automatic set_tbl(int i, int q, int g, int tt, int tg);
    cfg_write(3, 0, i, (32'(q) << 20) | (32'(g) << 12) | (32'(tt) << 8) | 32'(tg));
    t_qos[i] = q; t_grp[i] = g; t_tt[i] = tt; t_tag[i] = tg;
  endtask

  function automatic int exp_index(int e, int len);
    int v = 0;
    for (int y = 0; y < 8; y++) if (m_vld[e][y]) begin
      int b = m_skip[e] + (m_pos[e][y] >> 3);
      if (b < len && pkt[b][7 - (m_pos[e][y] % 8)]) v |= 1 << y;
    end
    return (v + m_off[e]) % 512;
  endfunction
  function automatic int exp_trig(int e, int len);
    int far = 0;
    for (int y = 0; y < 8; y++) if (m_vld[e][y] && (m_pos[e][y] >> 3) > far) far = m_pos[e][y] >> 3;
    return (m_skip[e] + far < len) ? m_skip[e] + far : len - 1;
  endfunction

  task automatic run_pkt(int port, bit incl, int len, string req);
    int e = port % 4, idx = exp_index(port % 4, len), t = exp_trig(port % 4, len), tc = 0;
    longint etag = (incl ? 0 : longint'(m_up[e]) << 16) | (m_tagb[e] << 8) | t_tag[idx];
    pulses = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      pkt_valid = 1; pkt_sop = (k == 0); pkt_eop = (k == len - 1); pkt_data = pkt[k];
      if (k == 0) begin pkt_port = 6'(port); pkt_incl_port = incl; end
      if (k == t) tc = cyc;
    end
    @(negedge clk); pkt_valid = 0; pkt_sop = 0; pkt_eop = 0;
    repeat (5) @(negedge clk);
    check(pulses == 1, {req, " R7 one pulse"}, pulses, 1);
    check(got_cyc == tc + 2, {req, " R7 latency"}, got_cyc, tc + 2);
    check(g_qos == 3'(t_qos[idx]) && g_grp == 6'(t_grp[idx]) && g_tt == 2'(t_tt[idx]),
          {req, " R5 fields"}, {g_qos, g_grp, g_tt}, {3'(t_qos[idx]), 6'(t_grp[idx]), 2'(t_tt[idx])});
    check(g_tag == 32'(etag), {req, " R6 tag"}, g_tag, etag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int e = 0; e < 4; e++) begin
      m_skip[e] = 0; m_off[e] = 0; m_tagb[e] = 0; m_up[e] = 0;
      for (int s = 0; s < 8; s++) begin m_pos[e][s] = 0; m_vld[e][s] = 0; end
    end
    repeat (3) @(negedge clk);
    check(res_valid == 0, "R9 reset res_valid", res_valid, 0);
    rst_n = 1;
    for (int i = 0; i < 512; i++)
      set_tbl(i, $urandom % 8, $urandom % 64, $urandom % 4, $urandom % 256);

    // R9 / R2: never-written positions give index 0 even on all-ones bytes
    for (int k = 0; k < 128; k++) pkt[k] = 8'hFF;
    run_pkt(0, 0, 6, "R9 reset config");

    // R3: one position, MSB-first within byte 1 after skip 3
    set_ext(1, 3, 0, 8'h5A); set_pos(1, 2, 7'h0D);
    for (int k = 0; k < 128; k++) pkt[k] = 8'h00;
    pkt[4] = 8'h04; run_pkt(5, 0, 10, "R3 bit set");
    check(exp_index(1, 10) == 4, "R3 model index", exp_index(1, 10), 4);
    pkt[4] = 8'hFB; run_pkt(1, 1, 10, "R3 bit clear");

    // R4: offset wraparound
    set_ext(2, 0, 511, 8'h11); set_up(2, 16'hBEEF);
    for (int s = 0; s < 8; s++) set_pos(2, s, s);
    pkt[0] = 8'hFF; run_pkt(2, 0, 4, "R4 wrap 254");
    pkt[0] = 8'h80; run_pkt(6, 0, 4, "R4 wrap 0");
    check(exp_index(2, 4) == 0, "R4 model wrap", exp_index(2, 4), 0);

    // R6: include-port flag masks upper tag
    pkt[0] = 8'h3C; run_pkt(2, 1, 3, "R6 masked"); run_pkt(2, 0, 3, "R6 unmasked");
    run_pkt(2, 1, 1, "R8 single byte");

    // R7 / R8: largest skip and farthest position
    set_ext(3, 64, 7, 8'h99); set_up(3, 16'h1234); set_pos(3, 7, 127);
    for (int k = 0; k < 128; k++) pkt[k] = 8'h00;
    pkt[79] = 8'h01; run_pkt(3, 0, 100, "R7 far byte");
    run_pkt(3, 0, 80, "R7 exact length");
    run_pkt(7, 0, 50, "R8 short packet");

    // R1: random setups, random packets over all extractors
    for (int e = 0; e < 4; e++) begin
      set_ext(e, $urandom % 65, $urandom % 512, $urandom % 256);
      set_up(e, $urandom % 65536);
      for (int s = 0; s < 8; s++) set_pos(e, s, $urandom % 128);
    end
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 128; k++) pkt[k] = 8'($urandom);
      run_pkt($urandom % 64, 1'($urandom), 1 + $urandom % 90, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule